// File: doc/BRIEF.md
# Shared-Bus Microcoded Datapath

This block is the 16-bit execution datapath of a small microcoded processor. It holds eight general registers, a program counter, an instruction register, a memory address register, a memory data register, three condition flags and a branch-enable flag. All of them exchange data over one internal bus. In any cycle, one gate enable at most puts a source on that bus. An external control word, supplied by a control store outside this block, sets each cycle's register loads, bus gates, multiplexer selects and ALU operation.

A dedicated address adder sums a base and a sign-extended instruction offset. The base is the incremented PC or a register. The sum feeds the PC-next multiplexer, and through the address multiplexer it also reaches the bus and so the MAR. The address multiplexer can instead supply a zero-extended 8-bit trap vector. Memory is reached through a plain enable, a write select and a ready input. The MAR and MDR drive the address and write data.

Top module: `ubus_datapath`

## Requirements
- R1: After reset, PC, IR, MAR, MDR, BEN and all eight general registers are zero, and the flags read Z (cc_o = 3'b010, with bit 2 = N, bit 1 = Z and bit 0 = P).
- R2: PC, IR, MAR, MDR, CC and BEN each change only at a clock edge where their own load input is high.
- R3: When exactly one of gate_pc_i, gate_mdr_i, gate_alu_i or gate_addr_i is high, bus_o equals that source (PC, MDR, ALU result, address multiplexer). When none is high, bus_o is zero.
- R4: alu_op_i selects 0 = A+B, 1 = A&B, 2 = ~A and 3 = A. A is register sr1_i. B is the sign-extended IR[4:0] when opb_imm_i = 1, and register sr2_i otherwise.
- R5: The address adder sums a base and an offset. base_sel_i = 0 selects PC+1 and 1 selects register sr1_i. off_sel_i selects 0 = zero, 1 = sext IR[5:0], 2 = sext IR[8:0] and 3 = sext IR[10:0]. The result wraps modulo 2^16.
- R6: addr_src_i = 0 gives the zero-extended IR[7:0] on the address path, and 1 gives the address-adder sum.
- R7: On a PC load, pc_src_i selects the new PC: 0 = PC+1, 1 = bus, 2 = adder sum.
- R8: On a CC load, exactly one flag is set from the bus value: N if bit 15 is set, Z if the value is zero, P otherwise.
- R9: On a BEN load, BEN becomes (IR[11]&N) | (IR[10]&Z) | (IR[9]&P), using the flags held before that edge.
- R10: On an MDR load with mio_en_i low, MDR takes the bus. On a read (mio_en_i high, mem_write_i low), MDR takes mem_rdata_i only when mem_ready_i is high, and holds its value while ready is low.
- R11: mem_addr_o is the MAR and mem_wdata_o is the MDR. mem_en_o follows mio_en_i, and mem_we_o is mio_en_i AND mem_write_i.
- R12: With ld_reg_i high, the bus value is written at the clock edge into register dr_i. Both read ports return register contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ld_mar_i | input | 1 | Load MAR from bus |
| ld_mdr_i | input | 1 | Load MDR (bus or memory) |
| ld_ir_i | input | 1 | Load IR from bus |
| ld_ben_i | input | 1 | Load branch-enable flag |
| ld_cc_i | input | 1 | Load condition flags from bus |
| ld_pc_i | input | 1 | Load PC from PC-next mux |
| ld_reg_i | input | 1 | Write bus into register dr_i |
| gate_pc_i | input | 1 | Drive PC onto bus |
| gate_mdr_i | input | 1 | Drive MDR onto bus |
| gate_alu_i | input | 1 | Drive ALU result onto bus |
| gate_addr_i | input | 1 | Drive address path onto bus |
| base_sel_i | input | 1 | Adder base: 0 PC+1, 1 register |
| off_sel_i | input | 2 | Adder offset select |
| addr_src_i | input | 1 | Address path: 0 trap vector, 1 adder |
| pc_src_i | input | 2 | PC-next select |
| dr_i | input | 3 | Destination register |
| sr1_i | input | 3 | Source register 1 / base register |
| sr2_i | input | 3 | Source register 2 |
| opb_imm_i | input | 1 | ALU operand B: 1 immediate, 0 register |
| alu_op_i | input | 2 | ALU operation |
| mio_en_i | input | 1 | Memory access enable |
| mem_write_i | input | 1 | Memory write select |
| mem_ready_i | input | 1 | Memory access done |
| mem_rdata_i | input | 16 | Memory read data |
| mem_en_o | output | 1 | Memory enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory address (MAR) |
| mem_wdata_o | output | 16 | Memory write data (MDR) |
| bus_o | output | 16 | Internal bus value |
| ir_o | output | 16 | Instruction register |
| cc_o | output | 3 | Flags {N,Z,P} |
| ben_o | output | 1 | Branch enable |

## Verification
The assertions assume that the control word never raises more than one gate enable in a cycle. That is a property of the microcode, not of this block. Every stimulus step in the bench starts from an all-idle control word and raises a single gate. The bench never loads the PC with the unused select value 3. The bench reaches the registers only through the memory read path and the bus. Each value therefore enters through the MDR and leaves through a single gate, with an ALU pass or a PC gate used for observation.

// File: rtl/ubus_pkg.sv
package ubus_pkg;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_AND  = 2'd1,
        ALU_NOT  = 2'd2,
        ALU_PASS = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        OFF_ZERO = 2'd0,
        OFF_S6   = 2'd1,
        OFF_S9   = 2'd2,
        OFF_S11  = 2'd3
    } off_sel_e;

    typedef enum logic [1:0] {
        PCN_INC  = 2'd0,
        PCN_BUS  = 2'd1,
        PCN_SUM  = 2'd2,
        PCN_RSVD = 2'd3
    } pc_src_e;

    localparam logic [2:0] CC_NEG  = 3'b100;
    localparam logic [2:0] CC_ZERO = 3'b010;
    localparam logic [2:0] CC_POS  = 3'b001;

endpackage

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           we_i,
    input  logic [RAW-1:0] waddr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [RAW-1:0] raddr_a_i,
    input  logic [RAW-1:0] raddr_b_i,
    output logic [DW-1:0]  rdata_a_o,
    output logic [DW-1:0]  rdata_b_o
);

    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_ni) regs_q[i] <= '0;
            else         regs_q[i] <= regs_d[i];
        end
    end

    assign rdata_a_o = regs_q[raddr_a_i];
    assign rdata_b_o = regs_q[raddr_b_i];

    // R12: a write lands in the addressed register one edge later
    p_write_lands_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && raddr_a_i == waddr_i) |=> (rdata_a_o == $past(wdata_i)) || !$stable(raddr_a_i));

endmodule

// File: rtl/ubus_alu.sv
module ubus_alu
    import ubus_pkg::*;
#(
    parameter int DW  = 16,
    parameter int IMW = 5
) (
    input  alu_op_e        op_i,
    input  logic           use_imm_i,
    input  logic [IMW-1:0] imm_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_reg_i,
    output logic [DW-1:0]  y_o
);

    logic [DW-1:0] opb_w;

    always_comb begin
        opb_w = use_imm_i ? {{(DW-IMW){imm_i[IMW-1]}}, imm_i} : b_reg_i;
        unique case (op_i)
            ALU_ADD: y_o = a_i + opb_w;
            ALU_AND: y_o = a_i & opb_w;
            ALU_NOT: y_o = ~a_i;
            default: y_o = a_i;
        endcase
    end

    // R4: complement output never shares a set bit with its operand
    always_comb begin
        if (op_i == ALU_NOT) begin
            a_not_disjoint_r4: assert ((y_o & a_i) == '0);
        end
    end

endmodule

// File: rtl/ubus_addr_unit.sv
module ubus_addr_unit
    import ubus_pkg::*;
#(
    parameter int DW = 16,
    parameter int VW = 8
) (
    input  logic          base_reg_i,
    input  off_sel_e      off_sel_i,
    input  logic          use_sum_i,
    input  logic [DW-1:0] pc_i,
    input  logic [DW-1:0] reg_i,
    input  logic [10:0]   ir_low_i,
    output logic [DW-1:0] sum_o,
    output logic [DW-1:0] path_o
);

    logic [DW-1:0] base_w;
    logic [DW-1:0] off_w;

    always_comb begin
        base_w = base_reg_i ? reg_i : pc_i + DW'(1);
        unique case (off_sel_i)
            OFF_ZERO: off_w = '0;
            OFF_S6:   off_w = {{(DW-6){ir_low_i[5]}},   ir_low_i[5:0]};
            OFF_S9:   off_w = {{(DW-9){ir_low_i[8]}},   ir_low_i[8:0]};
            default:  off_w = {{(DW-11){ir_low_i[10]}}, ir_low_i[10:0]};
        endcase
        sum_o  = base_w + off_w;
        path_o = use_sum_i ? sum_o : {{(DW-VW){1'b0}}, ir_low_i[VW-1:0]};
    end

    // R6: trap vector path never carries upper bits
    always_comb begin
        if (!use_sum_i) begin
            a_vec_upper_zero_r6: assert (path_o[DW-1:VW] == '0);
        end
    end

endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
    import ubus_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           ld_mar_i,
    input  logic           ld_mdr_i,
    input  logic           ld_ir_i,
    input  logic           ld_ben_i,
    input  logic           ld_cc_i,
    input  logic           ld_pc_i,
    input  logic           ld_reg_i,
    input  logic           gate_pc_i,
    input  logic           gate_mdr_i,
    input  logic           gate_alu_i,
    input  logic           gate_addr_i,
    input  logic           base_sel_i,
    input  logic [1:0]     off_sel_i,
    input  logic           addr_src_i,
    input  logic [1:0]     pc_src_i,
    input  logic [RAW-1:0] dr_i,
    input  logic [RAW-1:0] sr1_i,
    input  logic [RAW-1:0] sr2_i,
    input  logic           opb_imm_i,
    input  logic [1:0]     alu_op_i,
    input  logic           mio_en_i,
    input  logic           mem_write_i,
    input  logic           mem_ready_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           mem_en_o,
    output logic           mem_we_o,
    output logic [DW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    output logic [DW-1:0]  bus_o,
    output logic [DW-1:0]  ir_o,
    output logic [2:0]     cc_o,
    output logic           ben_o
);

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] mar;
        logic [DW-1:0] mdr;
        logic [2:0]    cc;
        logic          ben;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic [DW-1:0] sr1_data_w, sr2_data_w;
    logic [DW-1:0] alu_y_w, sum_w, addr_path_w, bus_w;

    ubus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (ld_reg_i),
        .waddr_i   (dr_i),
        .wdata_i   (bus_w),
        .raddr_a_i (sr1_i),
        .raddr_b_i (sr2_i),
        .rdata_a_o (sr1_data_w),
        .rdata_b_o (sr2_data_w)
    );

    ubus_alu #(.DW(DW), .IMW(5)) u_alu (
        .op_i      (alu_op_e'(alu_op_i)),
        .use_imm_i (opb_imm_i),
        .imm_i     (st_q.ir[4:0]),
        .a_i       (sr1_data_w),
        .b_reg_i   (sr2_data_w),
        .y_o       (alu_y_w)
    );

    ubus_addr_unit #(.DW(DW), .VW(8)) u_addr (
        .base_reg_i (base_sel_i),
        .off_sel_i  (off_sel_e'(off_sel_i)),
        .use_sum_i  (addr_src_i),
        .pc_i       (st_q.pc),
        .reg_i      (sr1_data_w),
        .ir_low_i   (st_q.ir[10:0]),
        .sum_o      (sum_w),
        .path_o     (addr_path_w)
    );

    // single shared bus; one gate at most per cycle
    always_comb begin
        if (gate_pc_i)        bus_w = st_q.pc;
        else if (gate_mdr_i)  bus_w = st_q.mdr;
        else if (gate_alu_i)  bus_w = alu_y_w;
        else if (gate_addr_i) bus_w = addr_path_w;
        else                  bus_w = '0;
    end

    always_comb begin
        st_d = st_q;
        if (ld_pc_i) begin
            unique case (pc_src_e'(pc_src_i))
                PCN_BUS: st_d.pc = bus_w;
                PCN_SUM: st_d.pc = sum_w;
                default: st_d.pc = st_q.pc + DW'(1);
            endcase
        end
        if (ld_ir_i)  st_d.ir  = bus_w;
        if (ld_mar_i) st_d.mar = bus_w;
        if (ld_mdr_i) begin
            if (!mio_en_i)                        st_d.mdr = bus_w;
            else if (!mem_write_i && mem_ready_i) st_d.mdr = mem_rdata_i;
        end
        if (ld_cc_i) begin
            if (bus_w[DW-1])       st_d.cc = CC_NEG;
            else if (bus_w == '0)  st_d.cc = CC_ZERO;
            else                   st_d.cc = CC_POS;
        end
        if (ld_ben_i) begin
            st_d.ben = (st_q.ir[11] & st_q.cc[2]) |
                       (st_q.ir[10] & st_q.cc[1]) |
                       (st_q.ir[9]  & st_q.cc[0]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.cc  <= CC_ZERO;
        end else begin
            st_q     <= st_d;
        end
    end

    assign mem_en_o    = mio_en_i;
    assign mem_we_o    = mio_en_i & mem_write_i;
    assign mem_addr_o  = st_q.mar;
    assign mem_wdata_o = st_q.mdr;
    assign bus_o       = bus_w;
    assign ir_o        = st_q.ir;
    assign cc_o        = st_q.cc;
    assign ben_o       = st_q.ben;

    // R3: control word raises at most one bus gate
    p_one_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({gate_pc_i, gate_mdr_i, gate_alu_i, gate_addr_i}));

    // R8: flags always hold exactly one of N, Z, P
    p_cc_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(cc_o) == 1);

    // R8: a negative bus value loads the N flag
    p_cc_neg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_cc_i && bus_o[DW-1]) |=> cc_o == CC_NEG);

    // R2: PC and IR hold without their loads
    p_pc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_pc_i |=> $stable(st_q.pc));
    p_ir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_ir_i |=> $stable(ir_o));

    // R10: MDR waits while a read is not yet done
    p_mdr_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_mdr_i && mio_en_i && !mem_write_i && !mem_ready_i) |=> $stable(mem_wdata_o));

    // R11: a write strobe only appears with the memory enable
    p_we_with_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> mem_en_o);

endmodule

// File: tb/tb_ubus_datapath.sv
`timescale 1ns/1ps
module tb_ubus_datapath;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic ld_mar, ld_mdr, ld_ir, ld_ben, ld_cc, ld_pc, ld_reg;
    logic g_pc, g_mdr, g_alu, g_addr;
    logic base_sel, addr_src, opb_imm, mio_en, mem_write, mem_ready;
    logic [1:0] off_sel, pc_src, alu_op;
    logic [2:0] dr, sr1, sr2;
    logic [15:0] rdata;
    logic mem_en, mem_we, ben;
    logic [15:0] maddr, wdata, bus, ir;
    logic [2:0] cc;

    ubus_datapath dut (
        .clk_i(clk), .rst_ni(rst_n),
        .ld_mar_i(ld_mar), .ld_mdr_i(ld_mdr), .ld_ir_i(ld_ir), .ld_ben_i(ld_ben),
        .ld_cc_i(ld_cc), .ld_pc_i(ld_pc), .ld_reg_i(ld_reg),
        .gate_pc_i(g_pc), .gate_mdr_i(g_mdr), .gate_alu_i(g_alu), .gate_addr_i(g_addr),
        .base_sel_i(base_sel), .off_sel_i(off_sel), .addr_src_i(addr_src), .pc_src_i(pc_src),
        .dr_i(dr), .sr1_i(sr1), .sr2_i(sr2), .opb_imm_i(opb_imm), .alu_op_i(alu_op),
        .mio_en_i(mio_en), .mem_write_i(mem_write), .mem_ready_i(mem_ready), .mem_rdata_i(rdata),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(maddr), .mem_wdata_o(wdata),
        .bus_o(bus), .ir_o(ir), .cc_o(cc), .ben_o(ben)
    );

    // observation kinds
    localparam int K_BUS = 0, K_IR = 1, K_CC = 2, K_BEN = 3,
                   K_ADDR = 4, K_WDATA = 5, K_EN = 6, K_WE = 7;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  chk_ev, chk_done;
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;

    function automatic logic [15:0] observe(int k);
        case (k)
            K_BUS:   return bus;
            K_IR:    return ir;
            K_CC:    return {13'd0, cc};
            K_BEN:   return {15'd0, ben};
            K_ADDR:  return maddr;
            K_WDATA: return wdata;
            K_EN:    return {15'd0, mem_en};
            default: return {15'd0, mem_we};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = observe(it.kind);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
            -> chk_done;
        end
    end

    // driver side: push one expectation and let the monitor consume it
    task automatic expect_obs(int k, logic [15:0] v, string req);
        item_t it;
        #1;
        it.kind = k; it.exp = v; it.req = req;
        q.push_back(it);
        -> chk_ev;
        @(chk_done);
    endtask

    task automatic idle();
        {ld_mar, ld_mdr, ld_ir, ld_ben, ld_cc, ld_pc, ld_reg} = '0;
        {g_pc, g_mdr, g_alu, g_addr} = '0;
        {base_sel, addr_src, opb_imm, mio_en, mem_write, mem_ready} = '0;
        off_sel = '0; pc_src = '0; alu_op = '0;
        dr = '0; sr1 = '0; sr2 = '0; rdata = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic mdr_from_mem(logic [15:0] v);
        idle(); mio_en = 1; ld_mdr = 1; mem_ready = 1; rdata = v;
        cyc(); idle();
    endtask

    task automatic write_reg(logic [2:0] r, logic [15:0] v);
        mdr_from_mem(v);
        g_mdr = 1; ld_reg = 1; dr = r;
        cyc(); idle();
    endtask

    task automatic load_ir(logic [15:0] v);
        mdr_from_mem(v);
        g_mdr = 1; ld_ir = 1;
        cyc(); idle();
    endtask

    task automatic cc_from_reg(logic [2:0] r);
        idle(); sr1 = r; alu_op = 2'd3; g_alu = 1; ld_cc = 1;
        cyc(); idle();
    endtask

    task automatic addr_probe(logic bsel, logic [1:0] osel, logic [2:0] r,
                              logic [15:0] v, string req);
        idle(); g_addr = 1; addr_src = 1; base_sel = bsel; off_sel = osel; sr1 = r;
        expect_obs(K_BUS, v, req);
        cyc();
    endtask

    task automatic alu_probe(logic [1:0] op, logic imm, logic [15:0] v);
        idle(); g_alu = 1; alu_op = op; opb_imm = imm; sr1 = 3'd1; sr2 = 3'd2;
        expect_obs(K_BUS, v, "R4");
        cyc();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        expect_obs(K_BUS, 16'h0000, "R1");
        expect_obs(K_IR, 16'h0000, "R1");
        cyc();
        expect_obs(K_CC, 16'h0002, "R1");
        expect_obs(K_BEN, 16'h0000, "R1");
        cyc();
        expect_obs(K_ADDR, 16'h0000, "R1");
        expect_obs(K_WDATA, 16'h0000, "R1");
        cyc();
        g_pc = 1;
        expect_obs(K_BUS, 16'h0000, "R1");
        cyc(); idle();
        // R1: register 3 reads zero through ALU pass
        sr1 = 3'd3; alu_op = 2'd3; g_alu = 1;
        expect_obs(K_BUS, 16'h0000, "R1");
        cyc(); idle();

        // R10/R11 read handshake: hold while not ready
        mio_en = 1; ld_mdr = 1; rdata = 16'h1234; mem_ready = 0;
        expect_obs(K_EN, 16'h0001, "R11");
        expect_obs(K_WE, 16'h0000, "R11");
        cyc();
        expect_obs(K_WDATA, 16'h0000, "R10");
        mem_ready = 1;
        cyc(); idle();
        expect_obs(K_WDATA, 16'h1234, "R10");
        cyc();
        // R3 gate and idle bus
        g_mdr = 1;
        expect_obs(K_BUS, 16'h1234, "R3");
        cyc(); idle();
        expect_obs(K_BUS, 16'h0000, "R3");
        cyc();

        // R12 register writes
        write_reg(3'd1, 16'h0005);
        write_reg(3'd2, 16'h0003);
        write_reg(3'd7, 16'h8000);
        sr1 = 3'd1; alu_op = 2'd3; g_alu = 1;
        expect_obs(K_BUS, 16'h0005, "R12");
        cyc(); idle();
        sr1 = 3'd7; alu_op = 2'd3; g_alu = 1;
        expect_obs(K_BUS, 16'h8000, "R12");
        cyc(); idle();

        // R4 ALU with register operand
        alu_probe(2'd0, 1'b0, 16'h0008);
        alu_probe(2'd1, 1'b0, 16'h0001);
        alu_probe(2'd2, 1'b0, 16'hFFFA);
        alu_probe(2'd3, 1'b0, 16'h0005);
        // R4 immediate: IR[4:0] = 5'b11110 -> -2
        load_ir(16'h003E);
        expect_obs(K_IR, 16'h003E, "R4");
        cyc();
        alu_probe(2'd0, 1'b1, 16'h0003);
        alu_probe(2'd1, 1'b1, 16'h0004);

        // R8 flags
        cc_from_reg(3'd7);
        expect_obs(K_CC, 16'h0004, "R8");
        cc_from_reg(3'd0);
        expect_obs(K_CC, 16'h0002, "R8");
        cc_from_reg(3'd1);
        expect_obs(K_CC, 16'h0001, "R8");

        // R9 branch enable, IR[11]=1 IR[10]=0 IR[9]=1
        load_ir(16'h0A00);
        ld_ben = 1;
        cyc(); idle();
        expect_obs(K_BEN, 16'h0001, "R9");
        cc_from_reg(3'd0);                 // flags now Z, BEN not loaded
        expect_obs(K_BEN, 16'h0001, "R2");
        ld_ben = 1;
        cyc(); idle();
        expect_obs(K_BEN, 16'h0000, "R9");
        cc_from_reg(3'd7);
        ld_ben = 1;
        cyc(); idle();
        expect_obs(K_BEN, 16'h0001, "R9");

        // R7 PC loads
        mdr_from_mem(16'h3000);
        g_mdr = 1; ld_pc = 1; pc_src = 2'd1;
        cyc(); idle();
        g_pc = 1;
        expect_obs(K_BUS, 16'h3000, "R7");
        cyc(); idle();
        ld_pc = 1; pc_src = 2'd0;
        cyc(); idle();
        g_pc = 1;
        expect_obs(K_BUS, 16'h3001, "R7");
        cyc(); idle();

        // R5/R6 address path, IR = 0x0525
        load_ir(16'h0525);
        addr_probe(1'b0, 2'd0, 3'd0, 16'h3002, "R5");
        addr_probe(1'b0, 2'd1, 3'd0, 16'h2FE7, "R5");
        addr_probe(1'b0, 2'd2, 3'd0, 16'h2F27, "R5");
        addr_probe(1'b0, 2'd3, 3'd0, 16'h2D27, "R5");
        addr_probe(1'b1, 2'd0, 3'd1, 16'h0005, "R5");
        addr_probe(1'b1, 2'd1, 3'd1, 16'hFFEA, "R5");
        idle(); g_addr = 1; addr_src = 0;
        expect_obs(K_BUS, 16'h0025, "R6");
        cyc(); idle();
        // R7 PC from adder
        ld_pc = 1; pc_src = 2'd2; base_sel = 0; off_sel = 2'd2;
        cyc(); idle();
        g_pc = 1;
        expect_obs(K_BUS, 16'h2F27, "R7");
        cyc(); idle();

        // R11 MAR from trap vector, then R2 hold
        g_addr = 1; addr_src = 0; ld_mar = 1;
        cyc(); idle();
        expect_obs(K_ADDR, 16'h0025, "R11");
        g_pc = 1;
        cyc(); idle();
        expect_obs(K_ADDR, 16'h0025, "R2");
        expect_obs(K_IR, 16'h0525, "R2");
        cyc();
        mio_en = 1; mem_write = 1;
        expect_obs(K_WE, 16'h0001, "R11");
        cyc(); idle();
        // R10 MDR from bus
        sr1 = 3'd1; alu_op = 2'd3; g_alu = 1; ld_mdr = 1;
        cyc(); idle();
        expect_obs(K_WDATA, 16'h0005, "R10");
        cyc();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule